// File: doc/BRIEF.md
# Word-Oriented SPI Master with Register Interface

This block is a single-channel SPI master. Software drives it through a small memory-mapped register bus. To make one exchange, software loads a transmit word, then writes the control register with the enable, master and exchange-start bits set. It then polls until the exchange bit reads back as zero and reads the received word. A single exchange moves between 1 and 32 bits. The length comes from a five-bit field that holds the bit count minus one.

The control register also sets:
- the serial clock rate, as a power-of-two division of the system clock;
- the clock polarity and the clock phase;
- which of four chip-select outputs is used;
- the active level of the chip selects.

A write to the soft-reset location returns every register to zero and ends any exchange that is running. Register writes are single-cycle strobes on `busWr`. Reads are combinational from `busAddr`. Word offsets are decoded from address bits 4:2.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the following all read zero: receive data (0x00), transmit data (0x04), control (0x08) and period (0x18). All chip selects are high, and `sclk` and `mosi` are low.
- R2: A control write with bit 0 (enable), bit 1 (master) and bit 2 (exchange) all set starts an exchange. Bit 2 reads 1 while the exchange runs and reads 0 once it completes. The other control fields then read back exactly as written.
- R3: Control bits 12:8 hold the bit count N minus one. The master sends transmit bits N-1 down to 0, most significant first. After the exchange, the receive register holds the N bits taken from `miso` at its low end, first bit highest, with the upper bits zero.
- R4: With rate code c in control bits 18:16, one `sclk` period is 2^(c+2) system clocks. The exchange bit reads 1 for exactly N·2^(c+2) cycles, counted from the cycle after the starting write.
- R5: When no exchange is running, `sclk` equals control bit 4 (polarity). With control bit 5 (phase) clear, `miso` is sampled on the first edge of each bit. With bit 5 set, it is sampled on the second edge.
- R6: Control bits 25:24 pick which output `csOut` asserts during an exchange. Control bit 7 gives the asserted level: 1 means high, 0 means low. Every other chip select, and all of them when idle, sit at the opposite level.
- R7: A control write with bit 2 set but bit 0 or bit 1 clear starts nothing. Bit 2 reads 0, and the other fields are stored.
- R8: Control writes that arrive while an exchange runs are ignored, including one in the final cycle. The exchange completes with its original length, rate and data.
- R9: Any write to offset 0x00 clears control, transmit, receive and period to zero and ends a running exchange at once. This holds even when the write lands in the exchange's final cycle.
- R10: The period register at 0x18 stores bits 15:0, where bit 15 selects the 32 kHz reference as the sample-period source. Offsets 0x0C, 0x10, 0x14 and 0x1C read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| csOut | output | 4 | Chip-select outputs |

## Verification
Three events can fall on the same clock edge:
- the final serial-clock edge of an exchange, which loads the receive register and clears the exchange bit;
- a control write from software;
- a soft-reset write from software.

The bench computes the completion cycle from the rate code and bit count. It places a control write, and separately a soft-reset write, on exactly that edge. The judgement is that the control write must be lost: the control value read afterwards equals the one that started the exchange, and the received data is intact. The soft reset must win over the receive load: the receive register reads zero. A mid-exchange control write and a mid-exchange soft reset are also provoked and judged by the same rules.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int RATE_W = 3;
  localparam int SEL_W  = 2;
  localparam int IDX_W  = 3;

  // word indices (address bits 4:2)
  localparam logic [IDX_W-1:0] IDX_RXRST  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_TX     = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_PERIOD = 3'd6;

  // control bit positions
  localparam int B_EN   = 0;
  localparam int B_MST  = 1;
  localparam int B_XCH  = 2;
  localparam int B_POL  = 4;
  localparam int B_PHA  = 5;
  localparam int B_LVL  = 7;
  localparam int B_LEN  = 8;
  localparam int B_RATE = 16;
  localparam int B_SEL  = 24;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0307_1FFB;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [RATE_W-1:0] rate;
    logic [LEN_W-1:0]  lenM1;
    logic              ssHigh;
    logic              pha;
    logic              pol;
  } xferCfg_t;

  typedef struct packed {
    logic start;
    logic abort;
  } dpStrobe_t;

  function automatic xferCfg_t decodeCfg(input logic [WORD_W-1:0] w);
    xferCfg_t c;
    c.sel    = w[B_SEL +: SEL_W];
    c.rate   = w[B_RATE +: RATE_W];
    c.lenM1  = w[B_LEN +: LEN_W];
    c.ssHigh = w[B_LVL];
    c.pha    = w[B_PHA];
    c.pol    = w[B_POL];
    return c;
  endfunction
endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl import spi_word_pkg::*; #(
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = 5,
  parameter int PERIOD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] dpRxWord,
  output dpStrobe_t         stb,
  output xferCfg_t          loadCfg,
  output logic              idlePol,
  output logic              idleHigh,
  output logic [DATA_W-1:0] txWord
);
  logic [DATA_W-1:0]   ctrlQ, txQ, rxQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [IDX_W-1:0]    idx;
  logic wrRst, wrCtrl, wrTx, wrPer, startOk;
  logic unusedBits;

  assign idx        = busAddr[ADDR_W-1:2];
  assign unusedBits = ^busAddr[1:0];

  always_comb begin
    wrRst   = busWr && (idx == IDX_RXRST);
    wrTx    = busWr && (idx == IDX_TX);
    wrPer   = busWr && (idx == IDX_PERIOD);
    wrCtrl  = busWr && (idx == IDX_CTRL) && !dpBusy;
    startOk = wrCtrl && busWdata[B_XCH] && busWdata[B_EN] && busWdata[B_MST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      txQ     <= '0;
      rxQ     <= '0;
      periodQ <= '0;
    end else if (wrRst) begin
      ctrlQ   <= '0;
      txQ     <= '0;
      rxQ     <= '0;
      periodQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ   <= busWdata & CTRL_MASK;
      if (wrTx)   txQ     <= busWdata;
      if (wrPer)  periodQ <= busWdata[PERIOD_W-1:0];
      if (dpDone) rxQ     <= dpRxWord;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_RXRST:  busRdata = rxQ;
      IDX_TX:     busRdata = txQ;
      IDX_CTRL:   busRdata = ctrlQ | (DATA_W'(dpBusy) << B_XCH);
      IDX_PERIOD: busRdata = DATA_W'(periodQ);
      default:    busRdata = '0;
    endcase
  end

  assign stb.start = startOk;
  assign stb.abort = wrRst;
  assign loadCfg   = decodeCfg(busWdata);
  assign idlePol   = ctrlQ[B_POL];
  assign idleHigh  = ctrlQ[B_LVL];
  assign txWord    = txQ;
endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp import spi_word_pkg::*; #(
  parameter int DATA_W = WORD_W,
  parameter int CS_N   = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  xferCfg_t          loadCfg,
  input  logic              idlePol,
  input  logic              idleHigh,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_N-1:0]   csOut
);
  localparam int DIV_W  = (1 << RATE_W) + 1;
  localparam int EDGE_W = LEN_W + 1;

  xferCfg_t          act;
  logic              run, sclkQ;
  logic [DIV_W-1:0]  divCnt, halfM1;
  logic [EDGE_W-1:0] edgeCnt;
  logic [DATA_W-1:0] txSh, rxSh, rxNext;
  logic [RATE_W:0]   shAmt;
  logic tick, sampleNow, shiftNow, lastEdge, lvl;

  always_comb begin
    shAmt     = {1'b0, act.rate} + 1'b1;
    halfM1    = (DIV_W'(1) << shAmt) - DIV_W'(1);
    tick      = run && (divCnt == halfM1);
    sampleNow = tick && (edgeCnt[0] == act.pha);
    shiftNow  = tick && (edgeCnt[0] != act.pha) && !(act.pha && edgeCnt == '0);
    lastEdge  = tick && (edgeCnt == {act.lenM1, 1'b1});
    rxNext    = {rxSh[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0; act <= '0; divCnt <= '0; edgeCnt <= '0;
      sclkQ <= 1'b0; txSh <= '0; rxSh <= '0;
    end else if (stb.abort) begin
      run <= 1'b0; divCnt <= '0; edgeCnt <= '0; sclkQ <= 1'b0;
      txSh <= '0; rxSh <= '0;
    end else if (stb.start) begin
      run     <= 1'b1;
      act     <= loadCfg;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkQ   <= loadCfg.pol;
      txSh    <= txWord << (LEN_W'(DATA_W - 1) - loadCfg.lenM1);
      rxSh    <= '0;
    end else if (tick) begin
      divCnt  <= '0;
      sclkQ   <= ~sclkQ;
      edgeCnt <= edgeCnt + 1'b1;
      if (sampleNow) rxSh <= rxNext;
      if (shiftNow)  txSh <= txSh << 1;
      if (lastEdge)  run  <= 1'b0;
    end else if (run) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign busy   = run;
  assign done   = lastEdge;
  assign rxWord = sampleNow ? rxNext : rxSh;
  assign sclk   = run ? sclkQ : idlePol;
  assign mosi   = txSh[DATA_W-1];
  assign lvl    = run ? act.ssHigh : idleHigh;

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign csOut[i] = (run && act.sel == SEL_W'(i)) ? lvl : ~lvl;
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master import spi_word_pkg::*; #(
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = 5,
  parameter int CS_N   = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_N-1:0]   csOut
);
  dpStrobe_t         stb;
  xferCfg_t          loadCfg;
  logic              idlePol, idleHigh, dpBusy, dpDone;
  logic [DATA_W-1:0] txWord, dpRxWord;

  spi_word_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dpBusy(dpBusy),
    .dpDone(dpDone), .dpRxWord(dpRxWord), .stb(stb), .loadCfg(loadCfg),
    .idlePol(idlePol), .idleHigh(idleHigh), .txWord(txWord)
  );

  spi_word_dp #(.DATA_W(DATA_W), .CS_N(CS_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadCfg(loadCfg),
    .idlePol(idlePol), .idleHigh(idleHigh), .txWord(txWord), .miso(miso),
    .busy(dpBusy), .done(dpDone), .rxWord(dpRxWord), .sclk(sclk),
    .mosi(mosi), .csOut(csOut)
  );
endmodule

// File: rtl/spi_word_chk.sv
module spi_word_chk import spi_word_pkg::*; #(
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = 5,
  parameter int CS_N   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              sclk,
  input logic [CS_N-1:0]   csOut,
  input logic              busy,
  input logic [DATA_W-1:0] ctrlQ
);
  logic ctrlWr, rstWr, goBits;
  assign ctrlWr = busWr && (busAddr[ADDR_W-1:2] == IDX_CTRL);
  assign rstWr  = busWr && (busAddr[ADDR_W-1:2] == IDX_RXRST);
  assign goBits = busWdata[B_EN] && busWdata[B_MST];

  AST_XCH_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !busy && busWdata[B_XCH] && goBits |=> busy); // R2
  AST_XCH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !busy && busWdata[B_XCH] && !goBits |=> !busy); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && !rstWr |=> $stable(ctrlQ)); // R8
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> !busy && ctrlQ == '0); // R9
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !busWr |=> $stable(sclk)); // R5
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(csOut) == 1 || $countones(csOut) == CS_N - 1)); // R6
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csOut == '0 || csOut == '1)); // R6
endmodule

bind spi_word_master spi_word_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_N(CS_N)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .sclk(sclk), .csOut(csOut), .busy(dpBusy),
  .ctrlQ(u_ctrl.ctrlQ)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  wire  [31:0] busRdata;
  wire         sclk, mosi, miso;
  wire  [3:0]  csOut;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_word_master u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csOut(csOut)
  );

  // behavioural slave
  logic [31:0] slvSh = '0, slvRx = '0;
  bit slvOn = 0, slvLead = 0, tPol = 0, tPha = 0;
  assign miso = slvSh[31];
  always @(sclk) if (slvOn) begin
    if (sclk != tPol) begin
      if (!tPha) slvRx = {slvRx[30:0], mosi};
      else begin
        if (slvLead) slvSh = slvSh << 1;
        slvLead = 1;
      end
    end else begin
      if (tPha) slvRx = {slvRx[30:0], mosi};
      else slvSh = slvSh << 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] lowMask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic t_reset;
    logic [31:0] r;
    rd(5'h00, r); chk("R1 rx after reset", r, 0);
    rd(5'h04, r); chk("R1 tx after reset", r, 0);
    rd(5'h08, r); chk("R1 ctrl after reset", r, 0);
    rd(5'h18, r); chk("R1 period after reset", r, 0);
    chk("R1 cs idle", 32'(csOut), 32'hF);
    chk("R1 sclk/mosi idle", {30'd0, sclk, mosi}, 0);
  endtask

  task automatic runXfer(string tag, int n, int rate, bit pol, bit pha, int sel, bit hi,
                         logic [31:0] txw, logic [31:0] slvw,
                         int hookAt, logic [4:0] hookAddr, logic [31:0] hookData, bit expRst);
    logic [31:0] cfg, r;
    logic [3:0]  csMid, csExp;
    int cyc, expCyc;
    cfg = 32'h3 | (32'(pol) << 4) | (32'(pha) << 5) | (32'(hi) << 7) |
          (32'(n - 1) << 8) | (32'(rate) << 16) | (32'(sel) << 24);
    wr(5'h04, txw);
    wr(5'h08, cfg);
    tPol = pol; tPha = pha; slvSh = slvw << (32 - n); slvRx = '0; slvLead = 0; slvOn = 1;
    wr(5'h08, cfg | 32'h4);
    cyc = 0; csMid = '0;
    while (1) begin
      rd(5'h08, r);
      if (!r[2]) break;
      if (cyc == 0) csMid = csOut;
      cyc++;
      if (cyc == hookAt) begin busAddr = hookAddr; busWdata = hookData; busWr = 1'b1; end
      @(negedge clk);
      busWr = 1'b0;
    end
    slvOn = 0;
    expCyc = expRst ? hookAt : 2 * n * (1 << (rate + 1));
    csExp  = hi ? (4'd1 << sel) : ~(4'd1 << sel);
    chk({"R4 busy cycles ", tag}, 32'(cyc), 32'(expCyc));
    chk({"R6 cs during ", tag}, 32'(csMid), 32'(csExp));
    rd(5'h00, r);
    chk({"R3 rx word ", tag}, r, expRst ? 32'd0 : (slvw & lowMask(n)));
    rd(5'h08, r);
    chk({"R2 R8 ctrl after ", tag}, r, expRst ? 32'd0 : cfg);
    chk({"R6 cs after ", tag}, 32'(csOut), (expRst || !hi) ? 32'hF : 32'h0);
    chk({"R5 sclk idle ", tag}, 32'(sclk), expRst ? 32'd0 : 32'(pol));
    if (!expRst) chk({"R3 slave got ", tag}, slvRx, txw & lowMask(n));
  endtask

  task automatic t_ignore;
    logic [31:0] r, rx0;
    rd(5'h00, rx0);
    wr(5'h08, 32'h0000_0095);          // enable, exchange, pol, level; no master
    rd(5'h08, r); chk("R7 no-master ctrl", r, 32'h0000_0091);
    @(negedge clk); @(negedge clk);
    rd(5'h08, r); chk("R7 still idle", r, 32'h0000_0091);
    chk("R7 cs untouched", 32'(csOut), 32'h0);
    chk("R7 sclk idle", 32'(sclk), 32'd1);
    wr(5'h08, 32'h0000_0006);          // master, exchange; no enable
    @(negedge clk);
    rd(5'h08, r); chk("R7 no-enable ctrl", r, 32'h0000_0002);
    rd(5'h00, r); chk("R7 rx unchanged", r, rx0);
  endtask

  task automatic t_period;
    logic [31:0] r;
    wr(5'h18, 32'hFFFF_8001);
    rd(5'h18, r); chk("R10 period stored", r, 32'h0000_8001);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, r); chk("R10 0x0C reads zero", r, 0);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, r); chk("R10 0x10 reads zero", r, 0);
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, r); chk("R10 0x14 reads zero", r, 0);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, r); chk("R10 0x1C reads zero", r, 0);
    wr(5'h00, 32'h1);
    rd(5'h18, r); chk("R9 period cleared", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    runXfer("m0",   8, 0, 0, 0, 0, 0, 32'hA5, 32'h3C, 0, 5'h0, 0, 0);
    runXfer("m1",   8, 0, 0, 1, 1, 0, 32'h96, 32'hC3, 0, 5'h0, 0, 0);
    runXfer("m2",   8, 0, 1, 0, 2, 1, 32'h5A, 32'h81, 0, 5'h0, 0, 0);
    runXfer("m3",   8, 1, 1, 1, 3, 1, 32'h7E, 32'h18, 0, 5'h0, 0, 0);
    runXfer("n1",   1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h1, 0, 5'h0, 0, 0);
    runXfer("n32", 32, 0, 1, 1, 1, 0, 32'h8123_4567, 32'hDEAD_BEEF, 0, 5'h0, 0, 0);
    runXfer("n13", 13, 2, 0, 0, 2, 0, 32'hFFFF_F0F5, 32'h1ABC, 0, 5'h0, 0, 0);
    runXfer("r7",   4, 7, 1, 0, 0, 1, 32'h9, 32'h6, 0, 5'h0, 0, 0);
    t_ignore();
    t_period();
    runXfer("midctrl",  16, 1, 0, 1, 2, 1, 32'hBEEF, 32'h1234, 3, 5'h08, 32'h0000_00F3, 0);
    runXfer("lastctrl",  8, 0, 1, 0, 1, 0, 32'h3C, 32'hE7, 32, 5'h08, 32'h0300_0013, 0);
    runXfer("lastrst",   8, 0, 0, 1, 3, 1, 32'h11, 32'h22, 32, 5'h00, 32'h1, 1);
    runXfer("midrst",   12, 1, 1, 1, 0, 1, 32'hABC, 32'h555, 5, 5'h00, 32'h1, 1);
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule